// File: doc/BRIEF.md
# Configurable ADC Result Output Port

This block hands a finished conversion word to a host through one of two faces. One input picks between them. The parallel face drives the word onto a data bus while the host holds chip select and read low. It can send the whole word at once or one byte per read. A byte-swap input sets which byte comes first or sits high. A coding input selects plain binary or two's complement, the latter made by inverting the most significant bit.

The serial face sends each new result as a frame of 16 bits, most significant bit first, with a frame marker (sync) active for exactly those bits. As master, the block makes the serial clock itself from the system clock. Two data-bus pins shared with the parallel face set a divide ratio, which applies only when the read-during-convert input is low. As slave, the block shifts on a clock supplied by the host. In both roles the host can invert the clock sense and choose the active level of sync. All inputs are synchronous to the system clock except the external serial clock, which passes through a synchronizer.

Top module: `adc_result_port`

## Requirements
- R1: The data bus is driven (`bus_oe` all ones) only while `sel_serial` is 0, `cs_n` is 0 and `rd_n` is 0. Otherwise `bus_oe` is all zeros.
- R2: For a full-word read with `byte_swap`=0, `bus_out[15:8]` carries the high byte and `bus_out[7:0]` the low byte. With `byte_swap`=1 the two bytes trade places.
- R3: With `straight_bin`=1 the word is presented unchanged. With `straight_bin`=0 bit 15 is inverted. This applies on both faces.
- R4: In byte-wide mode (`byte_wide`=1) `bus_out[7:0]` is zero and the byte appears on `bus_out[15:8]`. The first read after a new result returns the high byte when `byte_swap`=0 and the low byte when `byte_swap`=1. Each later read, counted when `rd_n` returns high with `cs_n` low, alternates to the other byte.
- R5: With `sel_serial`=1 the whole bus, bits 1 and 0 included, is undriven (`bus_oe`=0) whatever `cs_n` and `rd_n` do.
- R6: In master mode (`sel_serial`=1, `clk_src_ext`=0) `sclk_oe` is 1. With `rd_during_conv`=0 the serial clock stays in each level for 2^`bus_div_in` system cycles, so one bit lasts 2^(`bus_div_in`+1) cycles.
- R7: With `rd_during_conv`=1 in master mode, `bus_div_in` is ignored and each clock level lasts one system cycle.
- R8: In slave mode (`clk_src_ext`=1) `sclk_oe` and `sclk_out` are 0. The frame advances one bit on each falling edge of the effective clock (`sclk_in` XOR `sclk_inv`), and `bus_div_in` has no effect.
- R9: A `res_valid` pulse in serial mode starts a frame of 16 bits, MSB first. Each bit is on `sdout` at the rising edge of the effective serial clock and holds while that clock is high.
- R10: Sync is active for exactly the 16 bits of a frame and inactive otherwise. Its active level is high when `sync_inv`=0 and low when `sync_inv`=1.
- R11: In master mode `sclk_out` equals the internal clock XOR `sclk_inv`. The internal clock idles low, so `sclk_out` idles at the value of `sclk_inv`.
- R12: After reset, `bus_oe`, `sclk_oe` and `sdout` are 0 and no frame is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| res_data | input | 16 | Conversion result word |
| res_valid | input | 1 | One-cycle strobe: res_data is a new result |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| sel_serial | input | 1 | 0 selects the parallel face, 1 the serial face |
| byte_wide | input | 1 | 1 selects one byte per read |
| byte_swap | input | 1 | Byte order select |
| straight_bin | input | 1 | 1 plain binary, 0 two's complement |
| clk_src_ext | input | 1 | 0 master (internal clock), 1 slave (external clock) |
| rd_during_conv | input | 1 | 1 disables the clock divider |
| sync_inv | input | 1 | 1 makes sync active low |
| sclk_inv | input | 1 | Inverts the serial clock sense |
| bus_div_in | input | 2 | Divide exponent taken from the shared bus pins |
| sclk_in | input | 1 | External serial clock (slave) |
| bus_out | output | 16 | Parallel data value |
| bus_oe | output | 16 | Per-bit drive enable for the data bus |
| sclk_out | output | 1 | Serial clock driven in master mode |
| sclk_oe | output | 1 | Drive enable for the serial clock pin |
| sdout | output | 1 | Serial data |
| sync_out | output | 1 | Frame marker |

## Verification
Parallel results are combinational, so each check is taken one step after the read strobes settle, between clock edges. The byte pointer moves at the first clock edge that sees `rd_n` high after a low, and the bench waits one full cycle before the next read. A master frame starts at the edge that samples `res_valid`, and its first serial rising edge comes 2^div cycles later. Serial bits are compared at each detected rising edge of the effective clock, sampled on the falling system edge, and the spacing between those edges checks the divide ratio. In slave mode the bench holds each phase of its clock for six cycles, longer than the three-cycle synchronizer and shift path, so each bit is settled when it is compared.

// File: rtl/arp_pkg.sv
package arp_pkg;

    typedef struct packed {
        logic serial;
        logic byte_wide;
        logic byte_swap;
        logic straight;
        logic ext_clk;
        logic rd_during;
        logic sync_inv;
        logic sclk_inv;
    } port_cfg_t;

    typedef enum logic {
        SH_IDLE = 1'b0,
        SH_RUN  = 1'b1
    } shift_state_t;

    function automatic logic is_master(input port_cfg_t c);
        return c.serial && !c.ext_clk;
    endfunction

    function automatic logic div_allowed(input port_cfg_t c);
        return is_master(c) && !c.rd_during;
    endfunction

    function automatic logic par_read(input port_cfg_t c, input logic cs_n, input logic rd_n);
        return !c.serial && !cs_n && !rd_n;
    endfunction

endpackage

// File: rtl/arp_coder.sv
module arp_coder #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] raw,
    input  logic              straight,
    output logic [DATA_W-1:0] coded
);
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            if (i == DATA_W - 1) begin : g_msb
                assign coded[i] = raw[i] ^ ~straight;
            end else begin : g_pass
                assign coded[i] = raw[i];
            end
        end
    endgenerate
endmodule

// File: rtl/arp_par_unit.sv
module arp_par_unit
    import arp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  port_cfg_t         cfg,
    input  logic [DATA_W-1:0] word,
    input  logic              new_result,
    input  logic              cs_n,
    input  logic              rd_n,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe
);
    localparam int HALF = DATA_W / 2;

    logic            rd_q;
    logic            second_sel;
    logic [HALF-1:0] hi_b, lo_b, first_b, other_b;
    logic            drive;

    assign hi_b    = word[DATA_W-1:HALF];
    assign lo_b    = word[HALF-1:0];
    assign first_b = cfg.byte_swap ? lo_b : hi_b;
    assign other_b = cfg.byte_swap ? hi_b : lo_b;
    assign drive   = par_read(cfg, cs_n, rd_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q       <= 1'b1;
            second_sel <= 1'b0;
        end else begin
            rd_q <= rd_n;
            if (new_result) begin
                second_sel <= 1'b0;
            end else if (cfg.byte_wide && !cfg.serial && !cs_n && rd_n && !rd_q) begin
                second_sel <= ~second_sel;
            end
        end
    end

    always_comb begin
        if (cfg.byte_wide) begin
            bus_out = {(second_sel ? other_b : first_b), {HALF{1'b0}}};
        end else if (cfg.byte_swap) begin
            bus_out = {lo_b, hi_b};
        end else begin
            bus_out = {hi_b, lo_b};
        end
        bus_oe = {DATA_W{drive}};
    end
endmodule

// File: rtl/arp_ser_clk.sv
module arp_ser_clk
    import arp_pkg::*;
#(
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  port_cfg_t        cfg,
    input  logic [DIV_W-1:0] div_pins,
    input  logic             sclk_in,
    input  logic             run,
    input  logic             start,
    output logic             tick,
    output logic             sclk_int
);
    localparam int HC_W = (1 << DIV_W) + 1;

    logic [DIV_W-1:0]       div_eff;
    logic [HC_W-1:0]        half_len;
    logic [HC_W-1:0]        hc;
    logic                   sclk_q;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   eff, eff_q;
    logic                   master, half_done;

    assign master    = is_master(cfg);
    assign div_eff   = div_allowed(cfg) ? div_pins : '0;
    assign half_len  = HC_W'(1) << div_eff;
    assign half_done = (hc == half_len - HC_W'(1));
    assign eff       = sync_q[SYNC_STAGES-1] ^ cfg.sclk_inv;
    assign sclk_int  = sclk_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '0;
            eff_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], sclk_in};
            eff_q  <= eff;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !master || !run || start) begin
            hc     <= '0;
            sclk_q <= 1'b0;
        end else if (half_done) begin
            hc     <= '0;
            sclk_q <= ~sclk_q;
        end else begin
            hc <= hc + HC_W'(1);
        end
    end

    always_comb begin
        if (!run || start) begin
            tick = 1'b0;
        end else if (master) begin
            tick = half_done && sclk_q;
        end else begin
            tick = eff_q && !eff;
        end
    end
endmodule

// File: rtl/arp_ser_shift.sv
module arp_ser_shift
    import arp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [DATA_W-1:0] load,
    input  logic              tick,
    output logic              run,
    output logic              msb
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    shift_state_t      state;
    logic [DATA_W-1:0] sh;
    logic [CNT_W-1:0]  left;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SH_IDLE;
            sh    <= '0;
            left  <= '0;
        end else if (start) begin
            state <= SH_RUN;
            sh    <= load;
            left  <= CNT_W'(DATA_W);
        end else if (tick && state == SH_RUN) begin
            sh   <= {sh[DATA_W-2:0], 1'b0};
            left <= left - CNT_W'(1);
            if (left == CNT_W'(1)) begin
                state <= SH_IDLE;
            end
        end
    end

    assign run = (state == SH_RUN);
    assign msb = sh[DATA_W-1];
endmodule

// File: rtl/adc_result_port.sv
module adc_result_port
    import arp_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int DIV_W       = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] res_data,
    input  logic              res_valid,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              sel_serial,
    input  logic              byte_wide,
    input  logic              byte_swap,
    input  logic              straight_bin,
    input  logic              clk_src_ext,
    input  logic              rd_during_conv,
    input  logic              sync_inv,
    input  logic              sclk_inv,
    input  logic [DIV_W-1:0]  bus_div_in,
    input  logic              sclk_in,
    output logic [DATA_W-1:0] bus_out,
    output logic [DATA_W-1:0] bus_oe,
    output logic              sclk_out,
    output logic              sclk_oe,
    output logic              sdout,
    output logic              sync_out
);
    port_cfg_t         cfg;
    logic [DATA_W-1:0] held, held_coded, load_coded;
    logic              start, tick, run, msb, sclk_int;

    assign cfg = '{serial:    sel_serial,
                   byte_wide: byte_wide,
                   byte_swap: byte_swap,
                   straight:  straight_bin,
                   ext_clk:   clk_src_ext,
                   rd_during: rd_during_conv,
                   sync_inv:  sync_inv,
                   sclk_inv:  sclk_inv};

    assign start = res_valid && cfg.serial;

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (res_valid) begin
            held <= res_data;
        end
    end

    arp_coder #(.DATA_W(DATA_W)) u_code_par (
        .raw(held), .straight(cfg.straight), .coded(held_coded)
    );

    arp_coder #(.DATA_W(DATA_W)) u_code_ser (
        .raw(res_data), .straight(cfg.straight), .coded(load_coded)
    );

    arp_par_unit #(.DATA_W(DATA_W)) u_par (
        .clk(clk), .rst(rst), .cfg(cfg), .word(held_coded),
        .new_result(res_valid), .cs_n(cs_n), .rd_n(rd_n),
        .bus_out(bus_out), .bus_oe(bus_oe)
    );

    arp_ser_clk #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_sclk (
        .clk(clk), .rst(rst), .cfg(cfg), .div_pins(bus_div_in),
        .sclk_in(sclk_in), .run(run), .start(start),
        .tick(tick), .sclk_int(sclk_int)
    );

    arp_ser_shift #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .start(start), .load(load_coded),
        .tick(tick), .run(run), .msb(msb)
    );

    assign sclk_oe  = is_master(cfg);
    assign sclk_out = sclk_oe & (sclk_int ^ cfg.sclk_inv);
    assign sdout    = run & msb;
    assign sync_out = cfg.serial & (run ^ cfg.sync_inv);
endmodule

// File: rtl/arp_chk.sv
module arp_chk #(
    parameter int DATA_W = 16,
    parameter int DIV_W  = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              res_valid,
    input logic              cs_n,
    input logic              rd_n,
    input logic              sel_serial,
    input logic              byte_wide,
    input logic              clk_src_ext,
    input logic              sync_inv,
    input logic              sclk_inv,
    input logic [DATA_W-1:0] bus_out,
    input logic [DATA_W-1:0] bus_oe,
    input logic              sclk_out,
    input logic              sclk_oe,
    input logic              sdout,
    input logic              sync_out
);
    localparam int HALF = DATA_W / 2;

    // R1
    par_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> bus_oe == '0);

    // R5
    serial_bus_z_chk: assert property (@(posedge clk) disable iff (rst)
        sel_serial |-> bus_oe == '0);

    // R4
    byte_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!sel_serial && byte_wide && !cs_n && !rd_n) |-> bus_out[HALF-1:0] == '0);

    // R8
    slave_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (sel_serial && clk_src_ext) |-> (!sclk_oe && !sclk_out));

    // R9
    sdout_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sclk_oe && $past(sclk_oe) && $stable(sclk_inv) &&
         (sclk_out ^ sclk_inv) && $past(sclk_out ^ sclk_inv)) |-> $stable(sdout));

    // R10
    frame_sync_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && sel_serial) |=>
            (!$stable(sync_inv) || !$stable(sel_serial) || sync_out != sync_inv));
endmodule

bind adc_result_port arp_chk #(.DATA_W(DATA_W), .DIV_W(DIV_W)) u_chk (.*);

// File: tb/adc_result_port_bench.sv
module adc_result_port_bench;
    localparam int CLK_PERIOD = 10;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] res_data = '0;
    logic         res_valid = 1'b0;
    logic         cs_n = 1'b1, rd_n = 1'b1;
    logic         sel_serial = 1'b0, byte_wide = 1'b0, byte_swap = 1'b0;
    logic         straight_bin = 1'b1, clk_src_ext = 1'b0, rd_during_conv = 1'b0;
    logic         sync_inv = 1'b0, sclk_inv = 1'b0, sclk_in = 1'b0;
    logic [1:0]   bus_div_in = 2'd0;
    logic [W-1:0] bus_out, bus_oe;
    logic         sclk_out, sclk_oe, sdout, sync_out;

    int n_chk = 0, n_bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    adc_result_port u_adc_result_port (
        .clk(clk), .rst(rst), .res_data(res_data), .res_valid(res_valid),
        .cs_n(cs_n), .rd_n(rd_n), .sel_serial(sel_serial), .byte_wide(byte_wide),
        .byte_swap(byte_swap), .straight_bin(straight_bin), .clk_src_ext(clk_src_ext),
        .rd_during_conv(rd_during_conv), .sync_inv(sync_inv), .sclk_inv(sclk_inv),
        .bus_div_in(bus_div_in), .sclk_in(sclk_in), .bus_out(bus_out), .bus_oe(bus_oe),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .sdout(sdout), .sync_out(sync_out)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // scoreboard
    logic  exp_q[$];
    int    cyc = 0, last_rise = 0, rises = 0, exp_period = 0;
    logic  mon_on = 1'b0, eff_prev = 1'b0;
    string period_tag = "R6";

    always @(negedge clk) begin
        logic eff;
        logic b;
        cyc++;
        eff = sclk_oe ? (sclk_out ^ sclk_inv) : (sclk_in ^ sclk_inv);
        if (mon_on && eff && !eff_prev) begin
            if (exp_q.size() == 0) begin
                check("R9 extra serial bit", 32'd1, 32'd0);
            end else begin
                b = exp_q.pop_front();
                check("R9 serial bit", {31'd0, sdout}, {31'd0, b});
                check("R10 sync active", {31'd0, sync_out}, {31'd0, ~sync_inv});
                if (exp_period != 0 && rises > 0)
                    check({period_tag, " bit period"}, cyc - last_rise, exp_period);
            end
            rises++;
            last_rise = cyc;
        end
        eff_prev = eff;
    end

    task automatic push_word(input logic [W-1:0] w);
        logic [W-1:0] c;
        c = straight_bin ? w : (w ^ 16'h8000);
        for (int i = W - 1; i >= 0; i--) exp_q.push_back(c[i]);
        rises = 0;
    endtask

    task automatic pulse_result(input logic [W-1:0] w);
        res_data  = w;
        res_valid = 1'b1;
        step(1);
        res_valid = 1'b0;
    endtask

    task automatic master_frame(input logic [W-1:0] w, input int period, input string tag);
        period_tag = tag;
        exp_period = period;
        check("R10 sync idle before frame", {31'd0, sync_out}, {31'd0, sync_inv});
        check("R11 sclk idle level", {31'd0, sclk_out}, {31'd0, sclk_inv});
        check("R6 sclk driven", {31'd0, sclk_oe}, 32'd1);
        push_word(w);
        mon_on = 1'b1;
        pulse_result(w);
        while (exp_q.size() != 0) step(1);
        step(2 * period);
        mon_on = 1'b0;
        check("R9 bit count", rises, 16);
        check("R10 sync idle after frame", {31'd0, sync_out}, {31'd0, sync_inv});
    endtask

    task automatic slave_frame(input logic [W-1:0] w);
        exp_period = 0;
        sclk_in = sclk_inv;
        step(6);
        check("R8 sclk not driven", {30'd0, sclk_oe, sclk_out}, 32'd0);
        check("R10 sync idle before frame", {31'd0, sync_out}, {31'd0, sync_inv});
        push_word(w);
        mon_on = 1'b1;
        pulse_result(w);
        for (int i = 0; i < W; i++) begin
            step(6);
            sclk_in = ~sclk_inv;
            step(6);
            sclk_in = sclk_inv;
        end
        step(6);
        mon_on = 1'b0;
        check("R8 bit count", rises, 16);
        check("R10 sync idle after frame", {31'd0, sync_out}, {31'd0, sync_inv});
    endtask

    task automatic par_read(input logic [W-1:0] exp, input string tag);
        cs_n = 1'b0;
        rd_n = 1'b0;
        #1;
        check({tag, " data"}, bus_out, exp);
        check("R1 bus driven", bus_oe, 16'hFFFF);
        step(1);
        rd_n = 1'b1;
        step(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        step(3);
        // R12 reset state
        check("R12 bus_oe in reset", bus_oe, 0);
        check("R12 serial outputs in reset", {30'd0, sclk_oe, sdout}, 0);
        rst = 1'b0;
        step(2);
        check("R12 no frame after reset", {31'd0, sync_out}, 0);

        // parallel, full word
        pulse_result(16'h1234);
        cs_n = 1'b1; rd_n = 1'b0; #1;
        check("R1 cs high", bus_oe, 0);
        cs_n = 1'b0; rd_n = 1'b1; #1;
        check("R1 rd high", bus_oe, 0);
        par_read(16'h1234, "R2 swap0 straight");
        byte_swap = 1'b1;
        par_read(16'h3412, "R2 swap1 straight");
        straight_bin = 1'b0;
        par_read(16'h3492, "R3 swap1 twos");
        byte_swap = 1'b0;
        par_read(16'h9234, "R3 swap0 twos");
        pulse_result(16'hA5C3);
        par_read(16'h25C3, "R3 msb set twos");
        straight_bin = 1'b1;
        par_read(16'hA5C3, "R2 second word");
        cs_n = 1'b1;

        // parallel, byte-wide
        byte_wide = 1'b1;
        pulse_result(16'hBEEF);
        par_read(16'hBE00, "R4 first byte swap0");
        par_read(16'hEF00, "R4 second byte swap0");
        par_read(16'hBE00, "R4 third byte swap0");
        byte_swap = 1'b1;
        pulse_result(16'h5A69);
        par_read(16'h6900, "R4 first byte swap1");
        par_read(16'h5A00, "R4 second byte swap1");
        straight_bin = 1'b0;
        pulse_result(16'h5A69);
        par_read(16'h6900, "R4 first byte twos");
        par_read(16'hDA00, "R3 R4 second byte twos");
        cs_n = 1'b1;
        byte_wide = 1'b0; byte_swap = 1'b0; straight_bin = 1'b1;

        // serial face releases bus
        sel_serial = 1'b1;
        cs_n = 1'b0; rd_n = 1'b0;
        step(4);
        check("R5 bus released", bus_oe, 0);
        cs_n = 1'b1; rd_n = 1'b1;

        // master frames
        bus_div_in = 2'd0;
        master_frame(16'hC35A, 2, "R6 div0");
        bus_div_in = 2'd1; sync_inv = 1'b1;
        step(4);
        master_frame(16'h8001, 4, "R6 div1");
        bus_div_in = 2'd3; sclk_inv = 1'b1; straight_bin = 1'b0;
        step(4);
        master_frame(16'h7E81, 16, "R6 div3");
        rd_during_conv = 1'b1;
        step(4);
        master_frame(16'h1F2E, 2, "R7 divider ignored");
        rd_during_conv = 1'b0; sclk_inv = 1'b0; sync_inv = 1'b0; straight_bin = 1'b1;

        // slave frames
        clk_src_ext = 1'b1;
        bus_div_in = 2'd3;
        step(4);
        slave_frame(16'hA55A);
        sclk_inv = 1'b1; sync_inv = 1'b1; straight_bin = 1'b0;
        step(4);
        slave_frame(16'h0F0F);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule